// File: doc/BRIEF.md
# Posted Serial-to-Internal-Bus Access Scheduler

This block sits between a two-wire serial slave framer and an on-chip parallel bus that a second host interface also uses. It turns each single-byte serial access into one internal-bus cycle. It keeps the time it holds the shared bus as short as possible.

Writes are posted. When the framer sees the Stop condition, it hands over the chip select, the 27-bit offset address and the data byte. The framer is then free to start the next serial transaction while the write runs on the internal bus. A second write that arrives while the single buffer is still occupied is held off by a stall flag, and the framer holds the serial clock low at its first acknowledge until the buffer frees.

Reads are issued on demand once the repeated-start slave address has arrived. The framer keeps the serial clock low until a completion pulse returns the data.

An arbiter shares the internal bus with the other host. A grant is never taken back in the middle of an access. Each access is stretched by a wait-state count, chosen by target class, and for external targets optionally by a ready input.

Top module: `posted_access_sched`

## Requirements
- R1: While reset is asserted, and after it is released, `ib_stb`, `oth_gnt`, `rd_done` and `wr_hold` are low, even when `wr_ack_wait` is high.
- R2: A pulse on `wr_post` while the buffer is free produces exactly one strobe access with `ib_we`=1 and the posted chip select, address, data and target class.
- R3: `wr_hold` is high whenever `wr_ack_wait` is high and a posted write has not yet completed on the internal bus. It falls once that write has completed.
- R4: A pulse on `rd_req` produces one strobe access with `ib_we`=0 and then a single-cycle `rd_done`, with `rd_data` equal to `ib_rdata` sampled in the last strobe cycle. With an idle bus and internal target, `rd_done` rises 4 + waits cycles after the clock edge that samples `rd_req`.
- R5: If a posted write is still pending when a read is requested, the write is issued before the read.
- R6: While the other host holds its grant, no serial strobe occurs. If both sides request the idle bus in the same cycle, the other host is granted.
- R7: Once `oth_gnt` is high, it stays high until `oth_req` falls, and `oth_gnt` is never high together with `ib_stb`.
- R8: An access to an internal target (`ext`=0) holds `ib_stb` for exactly 1 + `cfg_wait_int` cycles.
- R9: An access to an external target (`ext`=1) has one address-setup cycle between grant and strobe, so it completes one cycle later than an internal access with the same wait count. Its strobe lasts 1 + `cfg_wait_ext` cycles when ready is not in use.
- R10: When `cfg_rdy_en`=1 and the target is external, the strobe is held after the wait count expires until `ib_ready` is sampled high. `ib_ready` has no effect for internal targets or when `cfg_rdy_en`=0.
- R11: The serial side drops its bus request in the cycle after each access. A request from the other host that is pending at that point is granted before the next serial access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait_int | input | WAIT_W | Wait states for internal targets |
| cfg_wait_ext | input | WAIT_W | Wait states for external targets |
| cfg_rdy_en | input | 1 | Use `ib_ready` for external targets |
| wr_post | input | 1 | Framer posts a write at Stop |
| wr_cs | input | CS_W | Chip select of posted write |
| wr_ext | input | 1 | Posted write targets the external bus |
| wr_addr | input | ADDR_W | Offset address of posted write |
| wr_data | input | DATA_W | Data byte of posted write |
| wr_ack_wait | input | 1 | Framer is at the first ACK of a new write |
| wr_hold | output | 1 | Keep the serial clock low: buffer occupied |
| rd_req | input | 1 | Repeated-start address received, read wanted |
| rd_cs | input | CS_W | Chip select of read |
| rd_ext | input | 1 | Read targets the external bus |
| rd_addr | input | ADDR_W | Offset address of read |
| rd_done | output | 1 | Single-cycle read completion |
| rd_data | output | DATA_W | Read data, valid with `rd_done` |
| oth_req | input | 1 | Other host requests the internal bus |
| oth_gnt | output | 1 | Other host owns the internal bus |
| ib_stb | output | 1 | Internal-bus access strobe |
| ib_we | output | 1 | Access is a write |
| ib_ext | output | 1 | Access is routed to the external bus |
| ib_cs | output | CS_W | Chip select |
| ib_addr | output | ADDR_W | Offset address |
| ib_wdata | output | DATA_W | Write data |
| ib_rdata | input | DATA_W | Read data from target |
| ib_ready | input | 1 | Target ready |

## Verification
The main function is tried with four patterns, and each one tells apart a different mistake:
- A lone posted write shows whether the posted fields reach the bus intact and whether the wait count is applied exactly.
- Paired internal and external reads at equal wait counts isolate the setup cycle through their latency difference.
- Reads with `ib_ready` held low for a fixed number of strobe cycles show whether ready is honoured only for external targets with ready enabled.
- A contested sequence checks deferral, priority to the other host, write-before-read ordering and the stall flag:
  - the other host holds the bus while a write and a read queue up;
  - the other host then re-requests during the write strobe.

// File: rtl/pas_pkg.sv
package pas_pkg;

  typedef enum logic [1:0] {
    OWN_NONE,
    OWN_HOST,
    OWN_SER
  } own_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_STRB,
    ST_END
  } seq_e;

endpackage

// File: rtl/pas_arbiter.sv
// Two-party owner register: whoever owns the bus keeps it until it drops its request.
module pas_arbiter
  import pas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic ser_req,
  output logic host_gnt,
  output logic ser_gnt
);

  own_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_NONE: begin
        // the other host wins a tie
        if (host_req)     own_d = OWN_HOST;
        else if (ser_req) own_d = OWN_SER;
      end
      OWN_HOST: if (!host_req) own_d = OWN_NONE;
      OWN_SER:  if (!ser_req)  own_d = OWN_NONE;
      default:  own_d = OWN_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= own_d;
  end

  assign host_gnt = (own_q == OWN_HOST);
  assign ser_gnt  = (own_q == OWN_SER);

endmodule

// File: rtl/pas_postbuf.sv
// Single-entry buffer for a write posted at Stop.
module pas_postbuf #(
  parameter int CS_W   = 2,
  parameter int ADDR_W = 27,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [CS_W-1:0]   push_cs,
  input  logic              push_ext,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic [CS_W-1:0]   q_cs,
  output logic              q_ext,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_data
);

  logic full_q, full_d;
  logic load;

  assign load   = push & ~full_q;
  assign full_d = load | (full_q & ~pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_cs   <= push_cs;
      q_ext  <= push_ext;
      q_addr <= push_addr;
      q_data <= push_data;
    end
  end

  assign full = full_q;

endmodule

// File: rtl/pas_access.sv
// Access sequencer: picks the posted write or the pending read, requests the bus,
// inserts the external setup cycle and times the strobe.
module pas_access
  import pas_pkg::*;
#(
  parameter int CS_W   = 2,
  parameter int ADDR_W = 27,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait_int,
  input  logic [WAIT_W-1:0] cfg_wait_ext,
  input  logic              cfg_rdy_en,
  input  logic              wq_full,
  input  logic [CS_W-1:0]   wq_cs,
  input  logic              wq_ext,
  input  logic [ADDR_W-1:0] wq_addr,
  input  logic [DATA_W-1:0] wq_data,
  output logic              wq_pop,
  input  logic              rd_req,
  input  logic [CS_W-1:0]   rd_cs,
  input  logic              rd_ext,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ser_req,
  input  logic              ser_gnt,
  output logic              ib_stb,
  output logic              ib_we,
  output logic              ib_ext,
  output logic [CS_W-1:0]   ib_cs,
  output logic [ADDR_W-1:0] ib_addr,
  output logic [DATA_W-1:0] ib_wdata,
  input  logic [DATA_W-1:0] ib_rdata,
  input  logic              ib_ready
);

  localparam logic [WAIT_W-1:0] CNT_ONE  = WAIT_W'(1);
  localparam logic [WAIT_W-1:0] CNT_ZERO = '0;

  seq_e              st_q, st_d;
  logic              op_we_q, op_we_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              rp_q, rp_d, rd_load;
  logic [CS_W-1:0]   rp_cs_q;
  logic              rp_ext_q;
  logic [ADDR_W-1:0] rp_addr_q;
  logic [DATA_W-1:0] rdat_q;
  logic              rdat_load;
  logic              sel_ext;
  logic [WAIT_W-1:0] sel_waits;
  logic              rdy_stall;
  logic              read_end;

  // pending read capture
  assign rd_load  = rd_req & ~rp_q;
  assign read_end = (st_q == ST_END) & ~op_we_q;
  assign rp_d     = rd_load | (rp_q & ~read_end);

  always_ff @(posedge clk) begin
    if (rd_load) begin
      rp_cs_q   <= rd_cs;
      rp_ext_q  <= rd_ext;
      rp_addr_q <= rd_addr;
    end
  end

  // operand selection follows the operation latched at IDLE
  assign sel_ext   = op_we_q ? wq_ext : rp_ext_q;
  assign sel_waits = sel_ext ? cfg_wait_ext : cfg_wait_int;
  assign rdy_stall = cfg_rdy_en & sel_ext & ~ib_ready;

  always_comb begin
    st_d      = st_q;
    op_we_d   = op_we_q;
    cnt_d     = cnt_q;
    rdat_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wq_full) begin
          op_we_d = 1'b1;
          st_d    = ST_REQ;
        end else if (rp_q) begin
          op_we_d = 1'b0;
          st_d    = ST_REQ;
        end
      end
      ST_REQ: begin
        if (ser_gnt) begin
          cnt_d = sel_waits;
          st_d  = sel_ext ? ST_SETUP : ST_STRB;
        end
      end
      ST_SETUP: st_d = ST_STRB;
      ST_STRB: begin
        if (cnt_q != CNT_ZERO) begin
          cnt_d = cnt_q - CNT_ONE;
        end else if (!rdy_stall) begin
          st_d      = ST_END;
          rdat_load = ~op_we_q;
        end
      end
      ST_END:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_we_q <= 1'b0;
      cnt_q   <= '0;
      rp_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      op_we_q <= op_we_d;
      cnt_q   <= cnt_d;
      rp_q    <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rdat_load) rdat_q <= ib_rdata;
  end

  assign ser_req  = (st_q == ST_REQ) | (st_q == ST_SETUP) | (st_q == ST_STRB);
  assign ib_stb   = (st_q == ST_STRB);
  assign wq_pop   = (st_q == ST_END) & op_we_q;
  assign rd_done  = read_end;
  assign rd_data  = rdat_q;
  assign ib_we    = op_we_q;
  assign ib_ext   = sel_ext;
  assign ib_cs    = op_we_q ? wq_cs   : rp_cs_q;
  assign ib_addr  = op_we_q ? wq_addr : rp_addr_q;
  assign ib_wdata = wq_data;

endmodule

// File: rtl/posted_access_sched.sv
module posted_access_sched #(
  parameter int CS_W   = 2,
  parameter int ADDR_W = 27,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAIT_W-1:0] cfg_wait_int,
  input  logic [WAIT_W-1:0] cfg_wait_ext,
  input  logic              cfg_rdy_en,
  input  logic              wr_post,
  input  logic [CS_W-1:0]   wr_cs,
  input  logic              wr_ext,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack_wait,
  output logic              wr_hold,
  input  logic              rd_req,
  input  logic [CS_W-1:0]   rd_cs,
  input  logic              rd_ext,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  input  logic              oth_req,
  output logic              oth_gnt,
  output logic              ib_stb,
  output logic              ib_we,
  output logic              ib_ext,
  output logic [CS_W-1:0]   ib_cs,
  output logic [ADDR_W-1:0] ib_addr,
  output logic [DATA_W-1:0] ib_wdata,
  input  logic [DATA_W-1:0] ib_rdata,
  input  logic              ib_ready
);

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              wq_full, wq_pop, wq_ext;
  logic [CS_W-1:0]   wq_cs;
  logic [ADDR_W-1:0] wq_addr;
  logic [DATA_W-1:0] wq_data;
  logic              ser_req, ser_gnt;

  pas_postbuf #(
    .CS_W  (CS_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_postbuf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .push     (wr_post),
    .push_cs  (wr_cs),
    .push_ext (wr_ext),
    .push_addr(wr_addr),
    .push_data(wr_data),
    .pop      (wq_pop),
    .full     (wq_full),
    .q_cs     (wq_cs),
    .q_ext    (wq_ext),
    .q_addr   (wq_addr),
    .q_data   (wq_data)
  );

  pas_arbiter i_arbiter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .host_req(oth_req),
    .ser_req (ser_req),
    .host_gnt(oth_gnt),
    .ser_gnt (ser_gnt)
  );

  pas_access #(
    .CS_W  (CS_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WAIT_W(WAIT_W)
  ) i_access (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_wait_int(cfg_wait_int),
    .cfg_wait_ext(cfg_wait_ext),
    .cfg_rdy_en  (cfg_rdy_en),
    .wq_full     (wq_full),
    .wq_cs       (wq_cs),
    .wq_ext      (wq_ext),
    .wq_addr     (wq_addr),
    .wq_data     (wq_data),
    .wq_pop      (wq_pop),
    .rd_req      (rd_req),
    .rd_cs       (rd_cs),
    .rd_ext      (rd_ext),
    .rd_addr     (rd_addr),
    .rd_done     (rd_done),
    .rd_data     (rd_data),
    .ser_req     (ser_req),
    .ser_gnt     (ser_gnt),
    .ib_stb      (ib_stb),
    .ib_we       (ib_we),
    .ib_ext      (ib_ext),
    .ib_cs       (ib_cs),
    .ib_addr     (ib_addr),
    .ib_wdata    (ib_wdata),
    .ib_rdata    (ib_rdata),
    .ib_ready    (ib_ready)
  );

  // the framer stretches its first ACK while the buffer is still occupied
  assign wr_hold = wr_ack_wait & wq_full;

endmodule

// File: rtl/pas_checker.sv
module pas_checker #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ib_stb,
  input logic              ib_ext,
  input logic              oth_req,
  input logic              oth_gnt,
  input logic              ser_req,
  input logic              ser_gnt,
  input logic              rd_done,
  input logic [WAIT_W-1:0] cfg_wait_int,
  input logic [WAIT_W-1:0] cfg_wait_ext
);

  logic [7:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (ib_stb) len_q <= (len_q == 8'hFF) ? len_q : len_q + 8'd1;
    else             len_q <= '0;
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oth_gnt |-> !ib_stb);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (oth_gnt && oth_req) |=> oth_gnt);

  p_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ib_stb |-> ser_gnt);

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ib_stb) |-> !ser_req);

  p_intlen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ib_stb && len_q != 8'd0 && !ib_ext) |-> (len_q == 8'(cfg_wait_int) + 8'd1));

  p_extlen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ib_stb && len_q != 8'd0 && ib_ext) |-> (len_q >= 8'(cfg_wait_ext) + 8'd1));

endmodule

bind posted_access_sched pas_checker #(.WAIT_W(WAIT_W)) i_pas_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ib_stb      (ib_stb),
  .ib_ext      (ib_ext),
  .oth_req     (oth_req),
  .oth_gnt     (oth_gnt),
  .ser_req     (ser_req),
  .ser_gnt     (ser_gnt),
  .rd_done     (rd_done),
  .cfg_wait_int(cfg_wait_int),
  .cfg_wait_ext(cfg_wait_ext)
);

// File: tb/test_posted_access_sched.sv
`timescale 1ns/1ps
module test_posted_access_sched;

  logic        clk;
  logic        rst_n;
  logic [3:0]  cfg_wait_int, cfg_wait_ext;
  logic        cfg_rdy_en;
  logic        wr_post, wr_ext, wr_ack_wait, wr_hold;
  logic [1:0]  wr_cs, rd_cs, ib_cs;
  logic [26:0] wr_addr, rd_addr, ib_addr;
  logic [7:0]  wr_data, rd_data, ib_wdata, ib_rdata;
  logic        rd_req, rd_ext, rd_done;
  logic        oth_req, oth_gnt;
  logic        ib_stb, ib_we, ib_ext, ib_ready;

  int n_chk, n_fail;
  int rdy_low;

  // access log filled by the monitor
  int          acc_n;
  int          scnt;
  logic [26:0] acc_addr [64];
  logic [7:0]  acc_wdata[64];
  logic [1:0]  acc_cs   [64];
  logic        acc_we   [64];
  logic        acc_ext  [64];
  int          acc_len  [64];
  logic [26:0] cur_addr;
  logic [7:0]  cur_wdata;
  logic [1:0]  cur_cs;
  logic        cur_we, cur_ext;
  int          excl_bad;

  posted_access_sched i_posted_access_sched (
    .clk(clk), .rst_n(rst_n),
    .cfg_wait_int(cfg_wait_int), .cfg_wait_ext(cfg_wait_ext), .cfg_rdy_en(cfg_rdy_en),
    .wr_post(wr_post), .wr_cs(wr_cs), .wr_ext(wr_ext), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack_wait(wr_ack_wait), .wr_hold(wr_hold),
    .rd_req(rd_req), .rd_cs(rd_cs), .rd_ext(rd_ext), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data),
    .oth_req(oth_req), .oth_gnt(oth_gnt),
    .ib_stb(ib_stb), .ib_we(ib_we), .ib_ext(ib_ext), .ib_cs(ib_cs), .ib_addr(ib_addr),
    .ib_wdata(ib_wdata), .ib_rdata(ib_rdata), .ib_ready(ib_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor and ready model; ready is low during the first rdy_low strobe cycles
  always @(negedge clk) begin
    if (oth_gnt && ib_stb) excl_bad++;
    if (ib_stb) begin
      scnt++;
      cur_addr = ib_addr; cur_wdata = ib_wdata; cur_cs = ib_cs;
      cur_we = ib_we; cur_ext = ib_ext;
    end else if (scnt > 0) begin
      if (acc_n < 64) begin
        acc_addr[acc_n] = cur_addr; acc_wdata[acc_n] = cur_wdata;
        acc_cs[acc_n] = cur_cs; acc_we[acc_n] = cur_we;
        acc_ext[acc_n] = cur_ext; acc_len[acc_n] = scnt;
      end
      acc_n++;
      scnt = 0;
    end
    ib_ready = (scnt >= rdy_low);
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic post_write(input logic [1:0] cs, input logic ext,
                            input logic [26:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_cs = cs; wr_ext = ext; wr_addr = a; wr_data = d; wr_post = 1'b1;
    @(negedge clk);
    wr_post = 1'b0;
  endtask

  task automatic read_req(input logic [1:0] cs, input logic ext, input logic [26:0] a);
    @(negedge clk);
    rd_cs = cs; rd_ext = ext; rd_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // latency = negedges after the sampling edge until rd_done is seen
  task automatic do_read(input logic [1:0] cs, input logic ext, input logic [26:0] a,
                         output int lat, output logic [7:0] dat);
    @(negedge clk);
    rd_cs = cs; rd_ext = ext; rd_addr = a; rd_req = 1'b1;
    lat = 0;
    @(negedge clk);
    rd_req = 1'b0;
    lat = 1;
    while (!rd_done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    dat = rd_data;
    @(negedge clk);
  endtask

  task automatic wait_acc(input int target);
    for (int i = 0; i < 200 && acc_n < target; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    wr_ack_wait = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 stb in reset", ib_stb, 0);
    chk("R1 oth_gnt in reset", oth_gnt, 0);
    chk("R1 wr_hold in reset", wr_hold, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_done after reset", rd_done, 0);
    chk("R1 wr_hold after reset", wr_hold, 0);
    wr_ack_wait = 1'b0;
  endtask

  task automatic t_write;
    int base;
    cfg_wait_int = 4'd3;
    base = acc_n;
    post_write(2'd2, 1'b0, 27'h5A51234, 8'hC3);
    wait_acc(base + 1);
    chk("R2 access count", acc_n, base + 1);
    chk("R2 we", acc_we[base], 1);
    chk("R2 addr", acc_addr[base], 27'h5A51234);
    chk("R2 data", acc_wdata[base], 8'hC3);
    chk("R2 cs", acc_cs[base], 2);
    chk("R8 strobe length wait 3", acc_len[base], 4);
  endtask

  task automatic t_read_int;
    int lat, base;
    logic [7:0] d;
    cfg_wait_int = 4'd1;
    ib_rdata = 8'h9E;
    base = acc_n;
    do_read(2'd1, 1'b0, 27'h00000F0, lat, d);
    chk("R4 latency internal wait 1", lat, 6);
    chk("R4 read data", d, 8'h9E);
    chk("R4 we low", acc_we[base], 0);
    chk("R4 addr", acc_addr[base], 27'h00000F0);
    chk("R8 strobe length wait 1", acc_len[base], 2);
  endtask

  task automatic t_ext;
    int lat_i, lat_e, base;
    logic [7:0] d;
    cfg_wait_int = 4'd2; cfg_wait_ext = 4'd2;
    ib_rdata = 8'h11;
    do_read(2'd0, 1'b0, 27'h0000100, lat_i, d);
    base = acc_n;
    do_read(2'd3, 1'b1, 27'h4000001, lat_e, d);
    chk("R9 external one cycle slower", lat_e, lat_i + 1);
    chk("R9 external latency", lat_e, 8);
    chk("R9 external strobe length", acc_len[base], 3);
    chk("R9 ext routed", acc_ext[base], 1);
  endtask

  task automatic t_ready;
    int lat, base;
    logic [7:0] d;
    cfg_wait_ext = 4'd2; cfg_wait_int = 4'd2;
    rdy_low = 6;
    cfg_rdy_en = 1'b0;
    base = acc_n;
    do_read(2'd1, 1'b1, 27'h0000200, lat, d);
    chk("R10 ready ignored when disabled", acc_len[base], 3);
    cfg_rdy_en = 1'b1;
    base = acc_n;
    do_read(2'd1, 1'b1, 27'h0000201, lat, d);
    chk("R10 ready extends external", acc_len[base], 6);
    base = acc_n;
    do_read(2'd1, 1'b0, 27'h0000202, lat, d);
    chk("R10 ready ignored internal", acc_len[base], 3);
    rdy_low = 0;
    cfg_rdy_en = 1'b0;
  endtask

  task automatic t_defer;
    int base;
    cfg_wait_int = 4'd3;
    ib_rdata = 8'h3C;
    @(negedge clk); oth_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 other host granted", oth_gnt, 1);
    base = acc_n;
    post_write(2'd3, 1'b0, 27'h7FFFFFF, 8'h5A);
    wr_ack_wait = 1'b1;
    read_req(2'd0, 1'b0, 27'h0000001);
    repeat (20) @(negedge clk);
    chk("R6 no serial access under other grant", acc_n, base);
    chk("R3 hold while write pending", wr_hold, 1);
    oth_req = 1'b0;
    for (int i = 0; i < 50 && !ib_stb; i++) @(negedge clk);
    oth_req = 1'b1;
    for (int i = 0; i < 50 && !oth_gnt; i++) @(negedge clk);
    chk("R11 other granted between accesses", oth_gnt, 1);
    chk("R11 only the write done", acc_n, base + 1);
    chk("R3 hold released after write", wr_hold, 0);
    wr_ack_wait = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 read deferred", acc_n, base + 1);
    oth_req = 1'b0;
    for (int i = 0; i < 50 && !rd_done; i++) @(negedge clk);
    chk("R4 read data after deferral", rd_data, 8'h3C);
    @(negedge clk);
    chk("R5 first is write", acc_we[base], 1);
    chk("R5 write addr", acc_addr[base], 27'h7FFFFFF);
    chk("R5 second is read", acc_we[base + 1], 0);
    chk("R5 read addr", acc_addr[base + 1], 27'h0000001);
    chk("R7 no strobe under other grant", excl_bad, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; acc_n = 0; scnt = 0; excl_bad = 0; rdy_low = 0;
    rst_n = 1'b0;
    cfg_wait_int = '0; cfg_wait_ext = '0; cfg_rdy_en = 1'b0;
    wr_post = 1'b0; wr_cs = '0; wr_ext = 1'b0; wr_addr = '0; wr_data = '0; wr_ack_wait = 1'b0;
    rd_req = 1'b0; rd_cs = '0; rd_ext = 1'b0; rd_addr = '0;
    oth_req = 1'b0; ib_rdata = '0;
    t_reset;
    t_write;
    t_read_int;
    t_ext;
    t_ready;
    t_defer;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule